// File: doc/BRIEF.md
# HDLC Frame Address Filter

This block sits behind an HDLC deframer, which has already removed flags, undone bit stuffing and checked the CRC. It takes a byte stream marked with start-of-frame, end-of-frame and frame-good flags, plus a tag that says which line side (send or receive) the frame arrived on. It reads the first two bytes of each frame as a 16-bit address. For each frame it then decides whether the frame is forwarded to capture memory, and under which direction label. A free-running microsecond counter stamps every forwarded frame.

In the normal full-duplex arrangement, each line side has its own address and its own enable. With the enable set, a frame whose address differs from that side's address is discarded. With the enable clear, every frame on that side is forwarded. In half-duplex mode only one physical line is watched, and it is split into two logical directions by address. A frame that matches the send-side address is labelled send, and every other frame is labelled receive.

Both byte interfaces use valid/ready handshakes. An input byte is taken on a clock edge where `i_valid` and `i_ready` are both high. An output beat moves on an edge where `o_valid` and `o_ready` are both high. Once `o_valid` is high, it stays high and the beat stays unchanged until `o_ready` takes it. The first byte of a frame is held internally until its address can be judged. The second byte is accepted only when the two-entry output buffer is empty, so that both held bytes can be written into it together.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset, `o_valid` is 0 and `i_ready` is 1.
- R2: The frame address is the first byte in bits 15:8 and the second byte in bits 7:0. A frame matches only when all 16 bits equal the programmed address.
- R3: In full-duplex mode with the frame's side enable set, a frame whose address does not match produces no output beat.
- R4: In full-duplex mode with the frame's side enable clear, every frame is forwarded unchanged, with `o_dir` equal to `i_side` (0 = send, 1 = receive).
- R5: A forwarded frame comes out with its bytes in order. `o_sof` is set on the first beat only, `o_eof` on the last beat only, and `o_good` is copied from each input beat.
- R6: In half-duplex mode every frame is forwarded. `o_dir` is 0 when the address equals the send-side address and 1 otherwise. `i_side`, both enables and the receive-side address have no effect.
- R7: A one-byte frame (`i_sof` and `i_eof` on the same beat) never matches. It is dropped when the filter is enabled, forwarded when the filter is disabled, and labelled 1 in half-duplex mode.
- R8: The stamp counter is 0 at reset and advances by one every `TICKS_PER_US` clocks. Every beat of a frame carries the counter value from the edge on which the frame's first byte was taken.
- R9: While `o_ready` is low, `o_valid` holds and the beat stays unchanged. `i_ready` is low only while a beat is waiting at the output.
- R10: The beats of a forwarded frame come out one after another with no other frame in between. `o_dir` and `o_stamp` stay constant within the frame.
- R11: A byte taken while no frame is open and without `i_sof` set is discarded with no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_half | input | 1 | 1 = half-duplex routing by address |
| cfg_snd_en | input | 1 | Send-side filter enable |
| cfg_snd_addr | input | 16 | Send-side address |
| cfg_rcv_en | input | 1 | Receive-side filter enable |
| cfg_rcv_addr | input | 16 | Receive-side address |
| i_valid | input | 1 | Input byte valid |
| i_ready | output | 1 | Input byte accepted when high with `i_valid` |
| i_data | input | 8 | Input byte |
| i_sof | input | 1 | First byte of a frame |
| i_eof | input | 1 | Last byte of a frame |
| i_good | input | 1 | Frame-good flag from the deframer |
| i_side | input | 1 | Line side of the frame, 0 = send, 1 = receive |
| o_valid | output | 1 | Output beat valid |
| o_ready | input | 1 | Downstream accepts the beat |
| o_data | output | 8 | Output byte |
| o_sof | output | 1 | First beat of a forwarded frame |
| o_eof | output | 1 | Last beat of a forwarded frame |
| o_good | output | 1 | Frame-good flag, copied from the input |
| o_dir | output | 1 | Direction label, 0 = send, 1 = receive |
| o_stamp | output | 32 | Microsecond stamp of the frame |

## Verification
The assertions assume the upstream stream is well formed: each frame opens with `i_sof` and closes with `i_eof`, `i_side` is constant within a frame, and the configuration stays fixed while a frame's first two bytes are being taken. The stimulus only changes configuration after the last byte of a frame has been accepted. It only sends whole frames, apart from one deliberate stray byte outside any frame. The stall case holds `o_ready` low long enough for the output buffer to fill and the input to be refused.

// File: rtl/hafl_pkg.sv
package hafl_pkg;
  typedef enum logic [1:0] {
    ST_FIRST  = 2'd0,
    ST_SECOND = 2'd1,
    ST_BODY   = 2'd2
  } fstate_e;

  localparam logic DIR_SEND = 1'b0;
  localparam logic DIR_RECV = 1'b1;
endpackage

// File: rtl/hafl_ustamp.sv
module hafl_ustamp #(
  parameter int TICKS_PER_US = 250,
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] stamp
);
  localparam int PW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_US - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre   <= '0;
      stamp <= '0;
    end else if (pre == PRE_LAST) begin
      pre   <= '0;
      stamp <= stamp + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/hafl_match.sv
module hafl_match #(
  parameter int AW = 16
) (
  input  logic          half,
  input  logic          side,
  input  logic          have_two,
  input  logic [AW-1:0] addr,
  input  logic          snd_en,
  input  logic [AW-1:0] snd_addr,
  input  logic          rcv_en,
  input  logic [AW-1:0] rcv_addr,
  output logic          pass,
  output logic          dir
);
  import hafl_pkg::*;

  logic hit_snd, hit_rcv;

  always_comb begin
    hit_snd = have_two && (addr == snd_addr);
    hit_rcv = have_two && (addr == rcv_addr);
    if (half) begin
      pass = 1'b1;
      dir  = hit_snd ? DIR_SEND : DIR_RECV;
    end else if (side == DIR_RECV) begin
      pass = !rcv_en || hit_rcv;
      dir  = DIR_RECV;
    end else begin
      pass = !snd_en || hit_snd;
      dir  = DIR_SEND;
    end
  end
endmodule

// File: rtl/hafl_pair_buf.sv
module hafl_pair_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_one,
  input  logic         push_two,
  input  logic [W-1:0] wr_a,
  input  logic [W-1:0] wr_b,
  input  logic         pop,
  output logic         have,
  output logic         empty,
  output logic         full,
  output logic [W-1:0] head
);
  logic [W-1:0] q0, q1, nq0, nq1;
  logic [1:0]   cnt, ncnt;

  always_comb begin
    nq0  = q0;
    nq1  = q1;
    ncnt = cnt;
    if (pop && cnt != 2'd0) begin
      nq0  = q1;
      ncnt = cnt - 2'd1;
    end
    if (push_one || push_two) begin
      if (ncnt == 2'd0) nq0 = wr_a;
      else              nq1 = wr_a;
      ncnt = ncnt + 2'd1;
    end
    if (push_two) begin
      nq1  = wr_b;
      ncnt = ncnt + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= 2'd0;
      q0  <= '0;
      q1  <= '0;
    end else begin
      cnt <= ncnt;
      q0  <= nq0;
      q1  <= nq1;
    end
  end

  assign have  = (cnt != 2'd0);
  assign empty = (cnt == 2'd0);
  assign full  = (cnt == 2'd2);
  assign head  = q0;
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter #(
  parameter int BYTE_W = 8,
  parameter int TICKS_PER_US = 250,
  parameter int TS_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_half,
  input  logic                cfg_snd_en,
  input  logic [2*BYTE_W-1:0] cfg_snd_addr,
  input  logic                cfg_rcv_en,
  input  logic [2*BYTE_W-1:0] cfg_rcv_addr,
  input  logic                i_valid,
  output logic                i_ready,
  input  logic [BYTE_W-1:0]   i_data,
  input  logic                i_sof,
  input  logic                i_eof,
  input  logic                i_good,
  input  logic                i_side,
  output logic                o_valid,
  input  logic                o_ready,
  output logic [BYTE_W-1:0]   o_data,
  output logic                o_sof,
  output logic                o_eof,
  output logic                o_good,
  output logic                o_dir,
  output logic [TS_W-1:0]     o_stamp
);
  import hafl_pkg::*;

  localparam int AW = 2 * BYTE_W;
  localparam int BW = BYTE_W + 4 + TS_W;

  fstate_e           state;
  logic [BYTE_W-1:0] lead_q;
  logic              lead_good_q, side_q, pass_q, dir_q;
  logic [TS_W-1:0]   ts_q, now;

  logic buf_empty, buf_full, buf_have;
  logic take, have_two, dec_side, dec_pass, dec_dir, frame_dir;
  logic push_one, push_two, pop;
  logic [TS_W-1:0] frame_ts;
  logic [BW-1:0]   beat_cur, beat_lead, wr_a, head;

  hafl_ustamp #(.TICKS_PER_US(TICKS_PER_US), .TS_W(TS_W)) u_stamp (
    .clk(clk), .rst(rst), .stamp(now)
  );

  assign have_two = (state == ST_SECOND);
  assign dec_side = have_two ? side_q : i_side;

  hafl_match #(.AW(AW)) u_match (
    .half(cfg_half), .side(dec_side), .have_two(have_two),
    .addr({lead_q, i_data}),
    .snd_en(cfg_snd_en), .snd_addr(cfg_snd_addr),
    .rcv_en(cfg_rcv_en), .rcv_addr(cfg_rcv_addr),
    .pass(dec_pass), .dir(dec_dir)
  );

  // second byte needs room for two beats at once
  assign i_ready   = have_two ? buf_empty : !buf_full;
  assign take      = i_valid && i_ready;
  assign frame_dir = (state == ST_BODY) ? dir_q : dec_dir;
  assign frame_ts  = (state == ST_FIRST) ? now : ts_q;

  assign beat_cur  = {i_data, (state == ST_FIRST), i_eof, i_good, frame_dir, frame_ts};
  assign beat_lead = {lead_q, 1'b1, 1'b0, lead_good_q, dec_dir, ts_q};

  assign push_one = take && ((state == ST_FIRST && i_sof && i_eof && dec_pass) ||
                             (state == ST_BODY && pass_q));
  assign push_two = take && have_two && dec_pass;
  assign wr_a     = push_two ? beat_lead : beat_cur;
  assign pop      = o_valid && o_ready;

  hafl_pair_buf #(.W(BW)) u_buf (
    .clk(clk), .rst(rst),
    .push_one(push_one), .push_two(push_two),
    .wr_a(wr_a), .wr_b(beat_cur), .pop(pop),
    .have(buf_have), .empty(buf_empty), .full(buf_full), .head(head)
  );

  assign o_valid = buf_have;
  assign {o_data, o_sof, o_eof, o_good, o_dir, o_stamp} = head;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_FIRST;
      lead_q      <= '0;
      lead_good_q <= 1'b0;
      side_q      <= 1'b0;
      pass_q      <= 1'b0;
      dir_q       <= 1'b0;
      ts_q        <= '0;
    end else if (take) begin
      case (state)
        ST_FIRST: begin
          if (i_sof && !i_eof) begin
            lead_q      <= i_data;
            lead_good_q <= i_good;
            side_q      <= i_side;
            ts_q        <= now;
            state       <= ST_SECOND;
          end
        end
        ST_SECOND: begin
          pass_q <= dec_pass;
          dir_q  <= dec_dir;
          state  <= i_eof ? ST_FIRST : ST_BODY;
        end
        ST_BODY: begin
          if (i_eof) state <= ST_FIRST;
        end
        default: state <= ST_FIRST;
      endcase
    end
  end
endmodule

// File: rtl/hdlc_addr_filter_chk.sv
module hdlc_addr_filter_chk #(
  parameter int BYTE_W = 8,
  parameter int TS_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              i_ready,
  input logic              o_valid,
  input logic              o_ready,
  input logic [BYTE_W-1:0] o_data,
  input logic              o_sof,
  input logic              o_eof,
  input logic              o_good,
  input logic              o_dir,
  input logic [TS_W-1:0]   o_stamp
);
  logic            open_q, dir_q;
  logic [TS_W-1:0] stamp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      dir_q   <= 1'b0;
      stamp_q <= '0;
    end else if (o_valid && o_ready) begin
      open_q  <= !o_eof;
      dir_q   <= o_dir;
      stamp_q <= o_stamp;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    o_valid && !o_ready |=> o_valid && $stable({o_data, o_sof, o_eof, o_good, o_dir, o_stamp}));

  // R9
  stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !i_ready |-> o_valid);

  // R10
  frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (o_sof == !open_q));

  // R10
  frame_const_chk: assert property (@(posedge clk) disable iff (rst)
    o_valid && open_q |-> (o_dir == dir_q) && (o_stamp == stamp_q));
endmodule

bind hdlc_addr_filter hdlc_addr_filter_chk #(.BYTE_W(BYTE_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst(rst), .i_ready(i_ready), .o_valid(o_valid), .o_ready(o_ready),
  .o_data(o_data), .o_sof(o_sof), .o_eof(o_eof), .o_good(o_good),
  .o_dir(o_dir), .o_stamp(o_stamp)
);

// File: tb/hdlc_addr_filter_test.sv
module hdlc_addr_filter_test;
  localparam int T  = 5;
  localparam int SW = 16;
  localparam int EW = 8 + 4 + SW;
  localparam logic [15:0] ADDR_S = 16'h7E81;
  localparam logic [15:0] ADDR_R = 16'h3C0F;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, cfg_half, cfg_snd_en, cfg_rcv_en;
  logic [15:0] cfg_snd_addr, cfg_rcv_addr;
  logic i_valid, i_ready, i_sof, i_eof, i_good, i_side;
  logic [7:0] i_data;
  logic o_valid, o_ready, o_sof, o_eof, o_good, o_dir;
  logic [7:0] o_data;
  logic [SW-1:0] o_stamp;

  int checks = 0;
  int fails = 0;
  int unsigned cyc = 0;
  int rdy_mode = 0;
  bit stall = 1'b0;
  logic [EW-1:0] expq[$];
  string tagq[$];

  hdlc_addr_filter #(.BYTE_W(8), .TICKS_PER_US(T), .TS_W(SW)) uut (
    .clk(clk), .rst(rst), .cfg_half(cfg_half),
    .cfg_snd_en(cfg_snd_en), .cfg_snd_addr(cfg_snd_addr),
    .cfg_rcv_en(cfg_rcv_en), .cfg_rcv_addr(cfg_rcv_addr),
    .i_valid(i_valid), .i_ready(i_ready), .i_data(i_data), .i_sof(i_sof),
    .i_eof(i_eof), .i_good(i_good), .i_side(i_side),
    .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data), .o_sof(o_sof),
    .o_eof(o_eof), .o_good(o_good), .o_dir(o_dir), .o_stamp(o_stamp)
  );

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // collector: drives o_ready and checks each beat that will move at the next edge
  initial begin
    o_ready = 1'b0;
    forever begin
      bit rdy;
      logic [EW-1:0] got, e;
      string tag;
      @(negedge clk);
      if (stall) rdy = 1'b0;
      else case (rdy_mode)
        0: rdy = 1'b1;
        1: rdy = (cyc % 3) != 0;
        default: rdy = (cyc % 2) == 0;
      endcase
      o_ready = rdy;
      if (!rst && o_valid && rdy) begin
        got = {o_data, o_sof, o_eof, o_good, o_dir, o_stamp};
        if (expq.size() == 0) begin
          chk(1'b0, "R3", "unexpected beat", 64'(got), 64'd0);
        end else begin
          e = expq.pop_front();
          tag = tagq.pop_front();
          chk(got[EW-1:SW] == e[EW-1:SW], tag, "beat fields", 64'(got[EW-1:SW]), 64'(e[EW-1:SW]));
          // R8 R10: frame stamp on every beat
          chk(got[SW-1:0] == e[SW-1:0], "R8", "stamp", 64'(got[SW-1:0]), 64'(e[SW-1:0]));
        end
      end
    end
  end

  function automatic logic [7:0] byte_at(input int i, input logic [7:0] b0,
                                         input logic [7:0] b1, input int fn);
    if (i == 0) return b0;
    if (i == 1) return b1;
    return 8'(8'h40 + i + fn);
  endfunction

  // caller is at a negedge
  task automatic send_frame(input int len, input logic [7:0] b0, input logic [7:0] b1,
                            input bit side, input bit good, input int fn, input string tag);
    bit pass, dir, two, en;
    logic [15:0] ad, a;
    logic [SW-1:0] ts;
    two = (len >= 2);
    a = {b0, b1};
    if (cfg_half) begin
      pass = 1'b1;
      dir = !(two && a == cfg_snd_addr);
    end else begin
      en = side ? cfg_rcv_en : cfg_snd_en;
      ad = side ? cfg_rcv_addr : cfg_snd_addr;
      pass = !en || (two && a == ad);
      dir = side;
    end
    for (int i = 0; i < len; i++) begin
      i_valid = 1'b1;
      i_data = byte_at(i, b0, b1, fn);
      i_sof = (i == 0);
      i_eof = (i == len - 1);
      i_good = (i == len - 1) ? good : 1'b0;
      i_side = side;
      while (!i_ready) @(negedge clk);
      if (i == 0) begin
        ts = SW'(cyc / T);
        if (pass) begin
          for (int k = 0; k < len; k++) begin
            expq.push_back({byte_at(k, b0, b1, fn), (k == 0), (k == len - 1),
                            (k == len - 1) ? good : 1'b0, dir, ts});
            tagq.push_back(tag);
          end
        end
      end
      @(negedge clk);
    end
    i_valid = 1'b0;
    i_sof = 1'b0;
    i_eof = 1'b0;
  endtask

  initial begin
    int fn;
    rst = 1'b1;
    i_valid = 1'b0; i_data = '0; i_sof = 1'b0; i_eof = 1'b0; i_good = 1'b0; i_side = 1'b0;
    cfg_half = 1'b0; cfg_snd_en = 1'b0; cfg_rcv_en = 1'b0;
    cfg_snd_addr = ADDR_S; cfg_rcv_addr = ADDR_R;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(o_valid == 1'b0, "R1", "o_valid after reset", 64'(o_valid), 64'd0);
    chk(i_ready == 1'b1, "R1", "i_ready after reset", 64'(i_ready), 64'd1);

    // R11: stray byte outside a frame is discarded
    i_valid = 1'b1; i_data = 8'hEE; i_sof = 1'b0; i_eof = 1'b0; i_side = 1'b0;
    @(negedge clk);
    i_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(o_valid == 1'b0, "R11", "stray byte output", 64'(o_valid), 64'd0);

    // sweep: mode x enables x side x length x address case
    fn = 0;
    for (int h = 0; h < 2; h++)
      for (int es = 0; es < 2; es++)
        for (int er = 0; er < 2; er++)
          for (int sd = 0; sd < 2; sd++)
            for (int len = 1; len <= 3; len++)
              for (int ac = 0; ac < 4; ac++) begin
                logic [15:0] want;
                logic [7:0] b0, b1;
                string tag;
                bit en;
                cfg_half = h[0]; cfg_snd_en = es[0]; cfg_rcv_en = er[0];
                rdy_mode = fn % 3;
                // R2: address case 0 = both bytes match, 1 = high byte off, 2 = low byte off, 3 = both off
                want = (h == 1 || sd == 0) ? ADDR_S : ADDR_R;
                b0 = ac[0] ? ~want[15:8] : want[15:8];
                b1 = ac[1] ? (want[7:0] ^ 8'h01) : want[7:0];
                en = sd[0] ? er[0] : es[0];
                if (len == 1) tag = "R7";
                else if (h == 1) tag = "R6";
                else if (!en) tag = "R4";
                else if (ac == 0) tag = "R5";
                else tag = "R2";
                send_frame(len, b0, b1, sd[0], fn[0], fn, tag);
                fn++;
              end

    // R9: stall the output until the buffer fills and the input is refused
    cfg_half = 1'b0; cfg_snd_en = 1'b0; cfg_rcv_en = 1'b0; rdy_mode = 0;
    repeat (10) @(negedge clk);
    stall = 1'b1;
    fork
      send_frame(4, 8'h11, 8'h22, 1'b1, 1'b1, 7, "R9");
    join_none
    repeat (20) @(negedge clk);
    chk(o_valid == 1'b1, "R9", "o_valid held during stall", 64'(o_valid), 64'd1);
    chk(i_ready == 1'b0, "R9", "i_ready during stall", 64'(i_ready), 64'd0);
    chk(o_data == 8'h11, "R9", "held byte during stall", 64'(o_data), 64'h11);
    stall = 1'b0;
    wait fork;

    // R3: every expected beat drained and nothing left over
    for (int w = 0; w < 200 && expq.size() != 0; w++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R3", "beats still expected", 64'(expq.size()), 64'd0);
    chk(o_valid == 1'b0, "R3", "idle at end", 64'(o_valid), 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule